// File: doc/BRIEF.md
# Per-Context Buffer Trigger Controller

This block is the control engine of a single translation context that sits between a local line buffer and an outbound bus engine. It compares the buffer fill level with a programmable threshold and asks the outbound side either to drain the buffer with a 2D write (write mode) or to refill it with a 2D read prefetch (read mode). It counts the lines moved by the outbound engine. When the last line of a frame completes, it emits a one-cycle done pulse and then either switches the context off (one-shot) or keeps it running from line 0 (continuous).

Software-style commands arrive as single-cycle pulses: start, stop and flush. An idle request can also trigger a flush when auto-flush is enabled. A command only acts at a clean transaction boundary, meaning a rising edge where `xfer_busy` is low. A command that arrives while a transaction is in flight is held pending until the first such edge. The buffer storage and the bus engines are outside this block.

Top module: `ctx_trigger_ctrl`

## Requirements
- R1: After reset the context is disabled, `wr_req`, `rd_req` and `done` are 0, and `line` is 0.
- R2: In write mode (`cfg_mode` = 0) with the context enabled, `wr_req` is 1 whenever `buf_level` >= `cfg_trigger`.
- R3: In read mode (`cfg_mode` = 1) with the context enabled, `rd_req` is 1 whenever `buf_level` < `cfg_trigger`. `wr_req` and `rd_req` are never 1 together.
- R4: A command pulse seen while `xfer_busy` is 1 has no effect on `ctx_en` until the first rising edge at which `xfer_busy` is 0. At that edge it takes effect.
- R5: A start applied at a boundary sets `ctx_en` to 1 and `line` to 0, and clears any active flush. A stop applied at a boundary clears `ctx_en`.
- R6: A flush accepted at a boundary while the context is enabled in write mode makes `wr_req` 1 whenever `buf_level` is nonzero, even below the trigger. The flush ends as soon as `buf_level` is 0.
- R7: Each `xfer_done` pulse while the context is enabled in mode 0 or 1 advances `line` by one. After the line equal to `cfg_last_line` it returns to 0, so a value of 0 describes a one-line frame.
- R8: `done` is 1 in the same cycle as an `xfer_done` that completes line `cfg_last_line`, and is 0 otherwise.
- R9: With `cfg_oneshot` = 1 the context is disabled after the frame-end edge. With `cfg_oneshot` = 0 it stays enabled and restarts at line 0; continuous use expects `cfg_last_line` = 7.
- R10: When start and stop arrive in the same cycle, stop wins and the start is discarded, including a start still pending.
- R11: In mode 2 (direct buffer access) and mode 3 (reserved) neither request is raised and `line` does not move.
- R12: An `idle_req` with `cfg_autoflush` = 1 acts as a flush command. With `cfg_autoflush` = 0 it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Start pulse |
| cmd_stop | input | 1 | Stop pulse |
| cmd_flush | input | 1 | Flush pulse |
| idle_req | input | 1 | Idle request from power management |
| cfg_mode | input | 2 | 0 write, 1 read, 2 direct access, 3 reserved |
| cfg_oneshot | input | 1 | 1 disables the context at frame end |
| cfg_autoflush | input | 1 | Idle request triggers a flush |
| cfg_trigger | input | TRIG_W | Level threshold in buffer words |
| cfg_last_line | input | LINE_W | Last line number, counted from 0 |
| buf_level | input | LVL_W | Current buffer fill level |
| xfer_busy | input | 1 | Outbound transaction in flight |
| xfer_done | input | 1 | Outbound line transfer or prefetch finished |
| ctx_en | output | 1 | Context enabled |
| wr_req | output | 1 | 2D write request |
| rd_req | output | 1 | 2D prefetch request |
| line | output | LINE_W | Current line |
| done | output | 1 | Frame-end pulse |

## Verification
The hardest situations to reach from the ports are commands that collide with an open transaction. Examples are a start that is still pending when a stop arrives, or a frame end that lands in the same cycle as a start. Directed sequences hold `xfer_busy` high across command pulses and then release it. A long random phase then drives `xfer_busy`, `xfer_done`, the commands and the level with independent probabilities, so that pending commands, flushes and frame ends overlap in many orders. A bench-side model follows the requirements each cycle.

// File: rtl/ctx_trigger_ctrl.sv
module ctx_trigger_ctrl #(
  parameter int TRIG_W = 14,
  parameter int LINE_W = 13,
  parameter int LVL_W  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic              cmd_flush,
  input  logic              idle_req,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_oneshot,
  input  logic              cfg_autoflush,
  input  logic [TRIG_W-1:0] cfg_trigger,
  input  logic [LINE_W-1:0] cfg_last_line,
  input  logic [LVL_W-1:0]  buf_level,
  input  logic              xfer_busy,
  input  logic              xfer_done,
  output logic              ctx_en,
  output logic              wr_req,
  output logic              rd_req,
  output logic [LINE_W-1:0] line,
  output logic              done
);
  localparam logic [1:0] MODE_WR = 2'd0;
  localparam logic [1:0] MODE_RD = 2'd1;

  logic start_pend, stop_pend, flush_pend, flush_act;
  logic eff_stop, eff_start, eff_flush, xlate, at_last, adv, lvl_zero, above;

  assign eff_stop  = cmd_stop | stop_pend;
  assign eff_start = (cmd_start | start_pend) & ~eff_stop;
  assign eff_flush = cmd_flush | (idle_req & cfg_autoflush) | flush_pend;
  assign xlate     = (cfg_mode == MODE_WR) | (cfg_mode == MODE_RD);
  assign at_last   = line == cfg_last_line;
  assign adv       = ctx_en & xlate & xfer_done;
  assign lvl_zero  = buf_level == '0;
  assign above     = {1'b0, buf_level} >= {{(LVL_W+1-TRIG_W){1'b0}}, cfg_trigger};

  assign wr_req = ctx_en & (cfg_mode == MODE_WR) & (above | (flush_act & ~lvl_zero));
  assign rd_req = ctx_en & (cfg_mode == MODE_RD) & ~above;
  assign done   = adv & at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_pend <= 1'b0;
      stop_pend  <= 1'b0;
      flush_pend <= 1'b0;
      flush_act  <= 1'b0;
      ctx_en     <= 1'b0;
      line       <= '0;
    end else begin
      start_pend <= eff_start & xfer_busy;
      stop_pend  <= eff_stop & xfer_busy;
      flush_pend <= eff_flush & xfer_busy;
      if (adv) begin
        line <= at_last ? '0 : line + 1'b1;
        if (at_last && cfg_oneshot) ctx_en <= 1'b0;
      end
      if (!ctx_en || cfg_mode != MODE_WR || lvl_zero) flush_act <= 1'b0;
      else if (eff_flush && !xfer_busy)               flush_act <= 1'b1;
      if (!xfer_busy) begin
        if (eff_stop) ctx_en <= 1'b0;
        else if (eff_start) begin
          ctx_en    <= 1'b1;
          line      <= '0;
          flush_act <= 1'b0;
        end
      end
    end
  end

  // R3
  req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(wr_req && rd_req));
  // R5
  stop_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stop && !xfer_busy |=> !ctx_en);
  // R4
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_busy && !xfer_done |=> ctx_en == $past(ctx_en));
  // R9
  oneshot_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && cfg_oneshot && !cmd_start && !start_pend |=> !ctx_en);
  // R7
  line_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> line == '0);
  // R5
  start_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start && !cmd_stop && !stop_pend && !xfer_busy |=> ctx_en && line == '0);
  // R11
  direct_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode[1] |-> !wr_req && !rd_req && !done);
endmodule

// File: tb/ctx_trigger_ctrl_tb_top.sv
module ctx_trigger_ctrl_tb_top;
  localparam int TW = 14, LW = 13, VW = 15;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_start = 0, cmd_stop = 0, cmd_flush = 0, idle_req = 0;
  logic [1:0] cfg_mode = 0;
  logic cfg_oneshot = 0, cfg_autoflush = 0;
  logic [TW-1:0] cfg_trigger = 0;
  logic [LW-1:0] cfg_last_line = 0;
  logic [VW-1:0] buf_level = 0;
  logic xfer_busy = 0, xfer_done = 0;
  logic ctx_en, wr_req, rd_req, done;
  logic [LW-1:0] line;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  ctx_trigger_ctrl #(.TRIG_W(TW), .LINE_W(LW), .LVL_W(VW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .cmd_flush(cmd_flush), .idle_req(idle_req), .cfg_mode(cfg_mode),
    .cfg_oneshot(cfg_oneshot), .cfg_autoflush(cfg_autoflush),
    .cfg_trigger(cfg_trigger), .cfg_last_line(cfg_last_line),
    .buf_level(buf_level), .xfer_busy(xfer_busy), .xfer_done(xfer_done),
    .ctx_en(ctx_en), .wr_req(wr_req), .rd_req(rd_req), .line(line), .done(done));

  // requirement-level model
  logic m_en, m_fl, p_st, p_sp, p_fl;
  logic [LW-1:0] m_line;

  function automatic logic f_wr();
    return m_en && cfg_mode == 0 &&
      (int'(buf_level) >= int'(cfg_trigger) || (m_fl && buf_level != 0));
  endfunction
  function automatic logic f_rd();
    return m_en && cfg_mode == 1 && int'(buf_level) < int'(cfg_trigger);
  endfunction
  function automatic logic f_done();
    return m_en && cfg_mode < 2 && xfer_done && m_line == cfg_last_line;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en <= 0; m_fl <= 0; p_st <= 0; p_sp <= 0; p_fl <= 0; m_line <= 0;
    end else begin
      logic stp, sta, fls, en, fl;
      logic [LW-1:0] ln;
      stp = cmd_stop | p_sp;
      sta = (cmd_start | p_st) && !stp;
      fls = cmd_flush | (idle_req & cfg_autoflush) | p_fl;
      en = m_en; ln = m_line; fl = m_fl;
      if (m_en && cfg_mode < 2 && xfer_done) begin
        if (m_line == cfg_last_line) begin ln = 0; if (cfg_oneshot) en = 0; end
        else ln = m_line + 1;
      end
      if (m_en && cfg_mode == 0 && buf_level != 0 && (m_fl || (fls && !xfer_busy))) fl = 1;
      else fl = 0;
      if (!xfer_busy) begin
        if (stp) en = 0;
        else if (sta) begin en = 1; ln = 0; fl = 0; end
      end
      p_sp <= stp & xfer_busy; p_st <= sta & xfer_busy; p_fl <= fls & xfer_busy;
      m_en <= en; m_line <= ln; m_fl <= fl;
    end
  end

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic chk_line(input logic [LW-1:0] exp, input string req);
    checks++;
    if (line !== exp) begin
      errors++;
      $display("FAIL %s line: got %0d expected %0d at %0t", req, line, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
    cmd_start = 0; cmd_stop = 0; cmd_flush = 0; idle_req = 0; xfer_done = 0;
    #1;
  endtask

  task automatic model_cmp();
    chk(wr_req, f_wr(), "R2", "wr_req");
    chk(rd_req, f_rd(), "R3", "rd_req");
    chk(done, f_done(), "R8", "done");
    chk(ctx_en, m_en, "R5", "ctx_en");
    checks++;
    if (line !== m_line) begin
      errors++;
      $display("FAIL R7 line: got %0d expected %0d at %0t", line, m_line, $time);
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: got hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    #20 @(negedge clk); rst_n = 1; #1;
    // R1
    chk(ctx_en, 0, "R1", "ctx_en"); chk(wr_req, 0, "R1", "wr_req");
    chk(rd_req, 0, "R1", "rd_req"); chk(done, 0, "R1", "done"); chk_line(0, "R1");

    // R4 start while busy is held
    cfg_mode = 0; cfg_trigger = 10; buf_level = 12; cfg_last_line = 1; cfg_oneshot = 1;
    xfer_busy = 1; cmd_start = 1; step();
    chk(ctx_en, 0, "R4", "ctx_en while busy");
    step(); chk(ctx_en, 0, "R4", "ctx_en still busy");
    xfer_busy = 0; step();
    chk(ctx_en, 1, "R4", "ctx_en at boundary");
    chk(wr_req, 1, "R2", "wr_req at level 12");
    buf_level = 10; #1 chk(wr_req, 1, "R2", "wr_req at level == trigger");
    buf_level = 5;  #1 chk(wr_req, 0, "R2", "wr_req below trigger");

    // R6 flush
    cmd_flush = 1; step();
    chk(wr_req, 1, "R6", "wr_req during flush");
    buf_level = 0; #1 chk(wr_req, 0, "R6", "wr_req empty");
    step(); buf_level = 5; #1 chk(wr_req, 0, "R6", "flush over");

    // R7 R8 R9 one-shot frame of two lines
    xfer_done = 1; #1 chk(done, 0, "R8", "done mid frame");
    step(); chk_line(1, "R7");
    xfer_done = 1; #1 chk(done, 1, "R8", "done last line");
    step(); chk(ctx_en, 0, "R9", "oneshot disable"); chk_line(0, "R7");

    // R10 stop beats start
    cmd_start = 1; cmd_stop = 1; step();
    chk(ctx_en, 0, "R10", "stop wins");
    xfer_busy = 1; cmd_start = 1; step(); cmd_stop = 1; step(); xfer_busy = 0; step();
    chk(ctx_en, 0, "R10", "pending start dropped");

    // R5 R9 continuous with one-line frame
    cfg_oneshot = 0; cfg_last_line = 0; cmd_start = 1; step();
    chk(ctx_en, 1, "R5", "start"); chk_line(0, "R5");
    xfer_done = 1; #1 chk(done, 1, "R8", "one-line done");
    step(); chk(ctx_en, 1, "R9", "continuous rearm");

    // R3 read mode
    cfg_mode = 1; buf_level = 3; #1
    chk(rd_req, 1, "R3", "rd_req low level"); chk(wr_req, 0, "R3", "no wr in read");
    buf_level = 10; #1 chk(rd_req, 0, "R3", "rd_req at trigger");

    // R11 direct access
    cfg_mode = 2; cfg_last_line = 7; buf_level = 20; #1
    chk(wr_req, 0, "R11", "wr_req mode2"); chk(rd_req, 0, "R11", "rd_req mode2");
    xfer_done = 1; step(); chk_line(0, "R11");
    cfg_mode = 3; buf_level = 1; #1 chk(rd_req, 0, "R11", "rd_req mode3");

    // R12 idle auto flush
    cfg_mode = 0; buf_level = 5; cfg_autoflush = 0; idle_req = 1; step();
    chk(wr_req, 0, "R12", "idle ignored");
    cfg_autoflush = 1; idle_req = 1; step();
    chk(wr_req, 1, "R12", "idle flush");
    cmd_stop = 1; step(); chk(ctx_en, 0, "R5", "stop");

    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      cmd_start = ($urandom % 16) == 0;
      cmd_stop  = ($urandom % 40) == 0;
      cmd_flush = ($urandom % 30) == 0;
      idle_req  = ($urandom % 30) == 0;
      if ($urandom % 50 == 0) cfg_mode = 2'($urandom);
      if ($urandom % 60 == 0) cfg_oneshot = 1'($urandom);
      if ($urandom % 60 == 0) cfg_autoflush = 1'($urandom);
      if ($urandom % 80 == 0) cfg_trigger = TW'($urandom % 64);
      if ($urandom % 80 == 0) cfg_last_line = cfg_oneshot ? LW'($urandom % 6) : LW'(7);
      buf_level = VW'($urandom % 80);
      xfer_busy = ($urandom % 3) == 0;
      xfer_done = ($urandom % 4) == 0;
      #1 model_cmp();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule